// File: doc/BRIEF.md
# Byte Serializer with Loopback Select

This block is the transmit half of a line interface for SONET/SDH-style links. Upstream logic hands it one 8-bit word per byte period, and the block shifts that word out one bit at a time on a serial output, most significant bit first. Consecutive words follow each other with no idle slot between them. The block makes its own byte clock by dividing the serial clock by eight and drives that clock back to the data source. The source changes its word on the falling edge of the byte clock, and the block captures the word on the rising edge.

The serial clock comes from one of two sources. It is normally the local bit clock. When loop timing is selected, the received clock is used instead, so the whole transmit path runs on the recovered line clock. A rate input picks the line rate. In the high-rate mode (622.08 Mb/s, byte clock 77.76 MHz) every serial clock edge is one bit slot. In the low-rate mode (155.52 Mb/s, byte clock 19.44 MHz) the clock keeps the high-rate frequency and one edge in four opens a bit slot. A facility-loopback input replaces the transmitted stream with the received serial data. Clock multiplication and the analog line drivers are outside the block. The rate and loop-timing selects are static: they change only while reset is held.

Top module: `byte_serializer`

## Requirements
- R1: A serial clock edge taken with `rst_n` low forces `tx_bit` and `byte_clk` to 0. After reset is released, `tx_bit` stays 0 for the first 8 serial clock edges in high-rate mode, or the first 32 edges in low-rate mode. The next edge puts out the most significant bit of the first captured byte.
- R2: `byte_clk` has a period of 8 bit slots. It is high for 4 slots and low for 4 slots. It first rises 4 bit slots after reset is released.
- R3: `tx_byte` is sampled only at the serial clock edge on which `byte_clk` rises. Values it holds at any other time do not appear on `tx_bit`.
- R4: With `rate_hi` = 1, take a byte captured at edge E. Its bit 7 appears on `tx_bit` after edge E+5, and bits 6 down to 0 follow on the next seven edges. The next byte starts on the edge after that, with no gap.
- R5: With `rate_hi` = 0, each bit slot lasts 4 serial clock edges. A byte captured at edge E puts bit 7 out after edge E+17, and bit k comes out after edge E+17+4·(7−k). The bytes run back to back.
- R6: With `fac_loop` = 1, `tx_bit` after each serial clock edge equals the value of `rx_bit` sampled at that edge.
- R7: With `loop_timed` = 1, `clk_rx` is the serial clock. All of the timing in R1 to R5 is then counted in `clk_rx` edges, whatever `clk_bit` is doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Local serial bit clock |
| clk_rx | input | 1 | Received line clock, used as the serial clock when `loop_timed` = 1 |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the selected serial clock |
| rate_hi | input | 1 | 1 = 622.08 Mb/s (a bit slot on every edge), 0 = 155.52 Mb/s (a bit slot every 4 edges) |
| loop_timed | input | 1 | 1 = serial clock taken from `clk_rx`, 0 = from `clk_bit` |
| fac_loop | input | 1 | 1 = `tx_bit` carries the retimed `rx_bit` |
| rx_bit | input | 1 | Received serial data |
| tx_byte | input | 8 | Parallel byte from the upstream source, bit 7 sent first |
| byte_clk | output | 1 | Byte clock, the serial bit rate divided by eight, driven to the source |
| tx_bit | output | 1 | Serial output, registered |

## Verification
Every result is counted in serial clock edges from the rising edge of `byte_clk` that captures a byte. In high-rate mode the first bit of that byte is due 5 edges later and each further bit 1 edge later. In low-rate mode the first bit is due 17 edges later and each further bit 4 edges later. Facility loopback is due on the same edge that samples `rx_bit`. The bench waits on the byte-clock rise, steps exactly that many edges of the selected clock, and samples 1 ns after the edge. It checks the whole bit stream continuously across byte boundaries, which also catches gaps and slips. The quiet window after reset is checked edge by edge against the 8 or 32 edges given in R1.

// File: rtl/ser_pkg.sv
// Package: shared constants and types of the byte serializer.
// Assumes nothing beyond a single 8-bit transmit word by default.
package ser_pkg;

    // Default parallel word width and low-rate slot divider.
    localparam int unsigned SER_WORD_W   = 8;
    localparam int unsigned SER_SLOW_DIV = 4;

    // Line-rate select encoding on rate_hi.
    typedef enum logic {
        RATE_LOW  = 1'b0,
        RATE_HIGH = 1'b1
    } ser_rate_e;

endpackage

// File: rtl/ser_clk_sel.sv
// Module: selects the serial clock, local bit clock or received clock.
// Assumes the select changes only while the block is held in reset, so
// no glitch-free switching is needed.
module ser_clk_sel (
    input  logic clk_local,
    input  logic clk_loop,
    input  logic use_loop,
    output logic clk_out
);

    // Static clock mux.
    always_comb begin
        clk_out = use_loop ? clk_loop : clk_local;
    end

endmodule

// File: rtl/ser_slot_gen.sv
// Module: bit-slot enable. In high-rate mode every clock is a slot; in
// low-rate mode one clock in SLOW_DIV is a slot.
// Assumes rate_hi is static outside reset.
module ser_slot_gen
    import ser_pkg::*;
#(
    parameter int unsigned SLOW_DIV = SER_SLOW_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_hi,
    output logic slot_en
);

    generate
        if (SLOW_DIV > 1) begin : g_div
            localparam int unsigned DIV_W = $clog2(SLOW_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

            logic [DIV_W-1:0] div_cnt;

            // Free-running divider, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_cnt <= '0;
                end else if (div_cnt == DIV_LAST) begin
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end

            // Slot strobe: every clock at high rate, divider wrap at low rate.
            always_comb begin
                slot_en = (ser_rate_e'(rate_hi) == RATE_HIGH) || (div_cnt == DIV_LAST);
            end
        end else begin : g_nodiv
            // No divider configured: every clock is a slot.
            always_comb begin
                slot_en = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/ser_byte_div.sv
// Module: divide-by-word-width slot counter. Produces the byte clock and
// the capture and load strobes.
// Assumes DATA_W is even; reset is synchronous with the shift register so
// byte boundaries sit at a fixed clock edge after reset.
module ser_byte_div
    import ser_pkg::*;
#(
    parameter int unsigned DATA_W = SER_WORD_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_en,
    output logic byte_clk,
    output logic capture_now,
    output logic load_now
);

    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] SLOT_HALF = CNT_W'(DATA_W / 2);

    logic [CNT_W-1:0] slot_cnt;
    logic [CNT_W-1:0] slot_nxt;
    logic             bclk_q;

    // Next slot index, wrapping at the word width.
    always_comb begin
        slot_nxt = (slot_cnt == SLOT_LAST) ? '0 : slot_cnt + 1'b1;
    end

    // Slot counter and registered byte clock (high in the second half).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            bclk_q   <= 1'b0;
        end else if (slot_en) begin
            slot_cnt <= slot_nxt;
            bclk_q   <= (slot_nxt >= SLOT_HALF);
        end
    end

    // Strobes for the edge where byte_clk rises and the last-slot edge.
    always_comb begin
        capture_now = slot_en && (slot_cnt == SLOT_HALF - 1'b1);
        load_now    = slot_en && (slot_cnt == SLOT_LAST);
    end

    assign byte_clk = bclk_q;

endmodule

// File: rtl/ser_shift.sv
// Module: holding register, MSB-first shift register and the registered
// output with the facility-loopback select.
// Assumes capture and load strobes never coincide.
module ser_shift
    import ser_pkg::*;
#(
    parameter int unsigned DATA_W = SER_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic              capture_now,
    input  logic              load_now,
    input  logic              fac_loop,
    input  logic              rx_bit,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_bit
);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shift_q;
    logic              out_q;

    // Capture the upstream word at the byte-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (capture_now) begin
            hold_q <= tx_byte;
        end
    end

    // Load a new word after the last slot, otherwise shift left per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (load_now) begin
            shift_q <= hold_q;
        end else if (slot_en) begin
            shift_q <= {shift_q[DATA_W-2:0], 1'b0};
        end
    end

    // Output retiming: transmit MSB or the received bit in loopback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= fac_loop ? rx_bit : shift_q[DATA_W-1];
        end
    end

    assign tx_bit = out_q;

endmodule

// File: rtl/byte_serializer.sv
// Module: top of the byte serializer. Picks the serial clock, generates
// bit slots and the byte clock, and shifts each captured byte out MSB
// first, with a facility-loopback override on the serial output.
// Assumes rate_hi and loop_timed are changed only while rst_n is low.
module byte_serializer
    import ser_pkg::*;
#(
    parameter int unsigned DATA_W   = SER_WORD_W,
    parameter int unsigned SLOW_DIV = SER_SLOW_DIV
) (
    input  logic              clk_bit,
    input  logic              clk_rx,
    input  logic              rst_n,
    input  logic              rate_hi,
    input  logic              loop_timed,
    input  logic              fac_loop,
    input  logic              rx_bit,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              byte_clk,
    output logic              tx_bit
);

    logic ser_clk;
    logic slot_en;
    logic capture_now;
    logic load_now;

    ser_clk_sel u_clk_sel (
        .clk_local (clk_bit),
        .clk_loop  (clk_rx),
        .use_loop  (loop_timed),
        .clk_out   (ser_clk)
    );

    ser_slot_gen #(
        .SLOW_DIV (SLOW_DIV)
    ) u_slot_gen (
        .clk     (ser_clk),
        .rst_n   (rst_n),
        .rate_hi (rate_hi),
        .slot_en (slot_en)
    );

    ser_byte_div #(
        .DATA_W (DATA_W)
    ) u_byte_div (
        .clk         (ser_clk),
        .rst_n       (rst_n),
        .slot_en     (slot_en),
        .byte_clk    (byte_clk),
        .capture_now (capture_now),
        .load_now    (load_now)
    );

    ser_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk         (ser_clk),
        .rst_n       (rst_n),
        .slot_en     (slot_en),
        .capture_now (capture_now),
        .load_now    (load_now),
        .fac_loop    (fac_loop),
        .rx_bit      (rx_bit),
        .tx_byte     (tx_byte),
        .tx_bit      (tx_bit)
    );

endmodule

// File: rtl/byte_serializer_checker.sv
// Module: assertion checker for the byte serializer, bound to the top.
// Assumes rate_hi and fac_loop are static outside reset.
module byte_serializer_checker #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned SLOW_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic rate_hi,
    input logic fac_loop,
    input logic rx_bit,
    input logic byte_clk,
    input logic tx_bit
);

    localparam int unsigned HALF_FAST  = DATA_W / 2;
    localparam int unsigned HALF_SLOW  = (DATA_W / 2) * SLOW_DIV;
    localparam int unsigned QUIET_FAST = DATA_W + 1;
    localparam int unsigned QUIET_SLOW = DATA_W * SLOW_DIV + 1;

    logic        rst_seen = 1'b0;
    logic        bclk_q;
    logic [15:0] run_len;
    logic [15:0] since_rst;
    logic [15:0] half_len;
    logic [15:0] quiet_len;

    always_comb begin
        half_len  = 16'(rate_hi ? HALF_FAST : HALF_SLOW);
        quiet_len = 16'(rate_hi ? QUIET_FAST : QUIET_SLOW);
    end

    // Track previous byte clock, length of its current level, and age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            run_len   <= '0;
            since_rst <= '0;
        end else begin
            bclk_q    <= byte_clk;
            run_len   <= (byte_clk != bclk_q) ? 16'd1 : run_len + 16'd1;
            since_rst <= (since_rst == 16'hFFFF) ? since_rst : since_rst + 16'd1;
        end
    end

    // R1: an edge with reset low leaves both outputs low.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
        if (rst_seen) begin
            p_reset_r1: assert (!tx_bit && !byte_clk);
        end
    end

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst < quiet_len) && !fac_loop) |-> !tx_bit);

    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_clk != bclk_q) |-> (run_len == half_len));

    p_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= half_len);

    p_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fac_loop |=> (tx_bit == $past(rx_bit)));

endmodule

bind byte_serializer byte_serializer_checker #(
    .DATA_W   (DATA_W),
    .SLOW_DIV (SLOW_DIV)
) u_checker (
    .clk      (ser_clk),
    .rst_n    (rst_n),
    .rate_hi  (rate_hi),
    .fac_loop (fac_loop),
    .rx_bit   (rx_bit),
    .byte_clk (byte_clk),
    .tx_bit   (tx_bit)
);

// File: tb/byte_serializer_bench.sv
`timescale 1ns/1ps
module byte_serializer_bench;

    logic       clk_bit = 1'b0;
    logic       clk_rx  = 1'b0;
    logic       rst_n   = 1'b0;
    logic       rate_hi = 1'b1;
    logic       loop_timed = 1'b0;
    logic       fac_loop = 1'b0;
    logic       rx_bit  = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       byte_clk;
    logic       tx_bit;

    int tests = 0;
    int fails = 0;
    logic [7:0] seq [0:255];

    wire sclk = loop_timed ? clk_rx : clk_bit;

    always #2 clk_bit = ~clk_bit;
    always #3 clk_rx  = ~clk_rx;

    byte_serializer u_byte_serializer (
        .clk_bit    (clk_bit),
        .clk_rx     (clk_rx),
        .rst_n      (rst_n),
        .rate_hi    (rate_hi),
        .loop_timed (loop_timed),
        .fac_loop   (fac_loop),
        .rx_bit     (rx_bit),
        .tx_byte    (tx_byte),
        .byte_clk   (byte_clk),
        .tx_bit     (tx_bit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Hold reset over four edges of the selected clock, check R1, release.
    task automatic apply_reset(input logic rate, input logic lt, input logic fl);
        rst_n = 1'b0;
        rate_hi = rate;
        loop_timed = lt;
        fac_loop = fl;
        repeat (4) @(posedge sclk);
        #1;
        chk("R1 tx_bit in reset", {31'd0, tx_bit}, 32'd0);
        chk("R1 byte_clk in reset", {31'd0, byte_clk}, 32'd0);
        @(negedge sclk);
        rst_n = 1'b1;
    endtask

    // R1: output quiet until the first byte, then its MSB.
    task automatic quiet_run(input logic rate);
        int first;
        int zeros;
        first = rate ? 9 : 33;
        tx_byte = 8'hFF;
        apply_reset(rate, 1'b0, 1'b0);
        zeros = 0;
        for (int k = 1; k < first; k++) begin
            @(posedge sclk);
            #1;
            if (tx_bit !== 1'b0) zeros++;
        end
        chk("R1 quiet window", zeros, 0);
        @(posedge sclk);
        #1;
        chk("R1 first MSB", {31'd0, tx_bit}, 32'd1);
    endtask

    // R3: present the right byte only around the byte-clock rise.
    task automatic drive_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                @(negedge byte_clk);
                tx_byte = ~seq[i];
                repeat (2) @(posedge sclk);
                #1;
                tx_byte = seq[i];
            end
            @(posedge byte_clk);
            #1;
            tx_byte = ~seq[i] ^ 8'h3C;
        end
    endtask

    // R4/R5/R7: continuous MSB-first stream, sampled at the computed edges.
    task automatic stream_check(input int n, input int per, input int lat, input string tag);
        @(posedge byte_clk);
        repeat (lat) @(posedge sclk);
        #1;
        for (int j = 0; j < n * 8; j++) begin
            chk(tag, {31'd0, tx_bit}, {31'd0, seq[j / 8][7 - (j % 8)]});
            if (j < n * 8 - 1) begin
                repeat (per) @(posedge sclk);
                #1;
            end
        end
    endtask

    // R2: byte clock high for half a byte, low for half, period of a byte.
    task automatic period_check(input int half, input string tag);
        int bad;
        bad = 0;
        @(posedge byte_clk);
        for (int c = 1; c <= 2 * half; c++) begin
            @(posedge sclk);
            #1;
            if (byte_clk !== ((c < half) || (c == 2 * half))) bad++;
        end
        chk(tag, bad, 0);
    endtask

    task automatic stream_run(input int n, input logic rate, input logic lt, input string tag);
        int per;
        int lat;
        per = rate ? 1 : 4;
        lat = rate ? 5 : 17;
        tx_byte = seq[0];
        apply_reset(rate, lt, 1'b0);
        fork
            drive_bytes(n);
            stream_check(n, per, lat, tag);
            period_check(per * 4, lt ? "R2 R7 byte_clk period" : "R2 byte_clk period");
        join
    endtask

    // R6: serial output follows the retimed received data.
    task automatic loopback_run();
        logic p;
        apply_reset(1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 64; k++) begin
            p = 1'(((k * 13) >> 2) ^ k ^ (k >> 3));
            @(negedge sclk);
            rx_bit = p;
            @(posedge sclk);
            #1;
            chk("R6 facility loopback", {31'd0, tx_bit}, {31'd0, p});
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        quiet_run(1'b1);
        quiet_run(1'b0);

        for (int i = 0; i < 256; i++) seq[i] = 8'(i);
        stream_run(256, 1'b1, 1'b0, "R3 R4 fast stream");

        for (int i = 0; i < 64; i++) seq[i] = 8'(i * 37 + 5);
        stream_run(64, 1'b0, 1'b0, "R3 R5 slow stream");

        for (int i = 0; i < 32; i++) seq[i] = 8'(i * 91 + 17);
        stream_run(32, 1'b1, 1'b1, "R7 loop-timed stream");

        loopback_run();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule